// File: doc/BRIEF.md
# Streaming 64-bit Arithmetic and Shift Unit

This block applies one of five operations to a pair of 64-bit operands: wrapping addition, wrapping subtraction, a less-than test, and zero-filling logical shifts of the first operand by a separate 6-bit amount. A 4-bit code, sent with the operands, selects the operation. Any code that names no operation yields an all-zero result. One code (binary 1000) is reserved and must not be sent. An embedded check flags it if it is.

Operands enter through a valid/ready input port. One register holds the result until the consumer takes it, and that register drives a valid/ready output port. A transfer happens on a rising clock edge where valid and ready are both high. The input side is ready whenever the output register is empty or is being drained in the same cycle. A stalled result therefore holds new work off without losing anything. While the output waits, it keeps its data steady. A parameter switches the less-than test between signed two's-complement and unsigned operation. The default is signed.

Top module: `alu64_stream`

## Requirements
- R1: Code 0001 produces in_a + in_b, taken modulo 2^64.
- R2: Code 0010 produces in_a - in_b, taken modulo 2^64.
- R3: Code 1011 produces the 64-bit value 1 when in_a < in_b, and 64-bit zero otherwise. The comparison is signed two's-complement when SIGNED_LT=1 (the default) and unsigned otherwise. Bits 63..1 of this result are always zero.
- R4: Code 1110 produces in_a shifted right by in_shamt (0 to 63), with the vacated upper bits filled with zero.
- R5: Code 1100 produces in_a shifted left by in_shamt (0 to 63), with the vacated lower bits filled with zero.
- R6: Every other code produces zero. Code 1000 is reserved and is never presented with in_valid high.
- R7: An operation is accepted on a rising edge where in_valid and in_ready are both high. Its result appears on out_data, with out_valid high, after that edge. If out_ready is high at the next edge, out_valid drops unless a new operation is accepted on the same edge.
- R8: While out_valid is high and out_ready is low, out_data stays unchanged and in_ready is low.
- R9: While rst_n is low, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and code are presented |
| in_ready | output | 1 | Block can take an operation this cycle |
| in_op | input | 4 | Operation code |
| in_a | input | 64 | First operand, and the value that gets shifted |
| in_b | input | 64 | Second operand |
| in_shamt | input | 6 | Shift distance |
| out_valid | output | 1 | out_data holds an untaken result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 64 | Result |

## Verification
Operands that share a magnitude but differ in sign are the trap for the less-than test. Equal operands and the extreme values 0x8000... and 0x7FFF... are used as well. A comparator that ignored overflow, or that treated the operands as unsigned, would give a flipped bit on exactly these cases. Shifts by 0, by 1 and by 63 probe the first and last stages of the shifter. A stage wired to the wrong distance, or one that fills with ones, would corrupt the edge bits. Unassigned codes 0000 and 1111 must give zero, not a leftover adder value. A held result, followed by release into a waiting operation, checks that a stall loses no data and does not take the next operation early.

// File: rtl/alu64_pkg.sv
package alu64_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'b0001,
    OP_SUB  = 4'b0010,
    OP_RSVD = 4'b1000,
    OP_LT   = 4'b1011,
    OP_SHL  = 4'b1100,
    OP_SHR  = 4'b1110
  } alu_op_e;

  localparam int unsigned OP_W = 4;

endpackage

// File: rtl/alu64_addsub.sv
module alu64_addsub #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum
);
  logic [W-1:0] b_eff;

  // Subtract as a + ~b + 1 through one carry chain
  assign b_eff = b ^ {W{sub}};
  assign sum   = a + b_eff + {{(W-1){1'b0}}, sub};

  always_comb begin
    if (!sub) a_r1_add_mod : assert (sum == a + b);
    else      a_r2_sub_mod : assert (sum == a - b);
  end
endmodule

// File: rtl/alu64_lt.sv
module alu64_lt #(
  parameter bit SIGNED_LT = 1'b1
) (
  input  logic a_msb,
  input  logic b_msb,
  input  logic diff_msb,
  output logic less
);
  // When the top bits agree, a - b cannot overflow and its sign decides.
  // When they differ, the top bits alone decide.
  generate
    if (SIGNED_LT) begin : g_signed
      assign less = (a_msb ^ b_msb) ? a_msb : diff_msb;
    end else begin : g_unsigned
      assign less = (a_msb ^ b_msb) ? b_msb : diff_msb;
    end
  endgenerate
endmodule

// File: rtl/alu64_shift.sv
module alu64_shift #(
  parameter int unsigned W    = 64,
  parameter bit          LEFT = 1'b0,
  localparam int unsigned SW  = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stg [SW+1];

  assign stg[0] = din;

  // Logarithmic barrel: stage s moves by 2**s when amt[s] is set
  for (genvar s = 0; s < SW; s++) begin : g_stage
    if (LEFT) begin : g_l
      assign stg[s+1] = amt[s] ? (stg[s] << (2**s)) : stg[s];
    end else begin : g_r
      assign stg[s+1] = amt[s] ? (stg[s] >> (2**s)) : stg[s];
    end
  end

  assign dout = stg[SW];

  always_comb begin
    if (amt == '0) a_r4_zero_dist : assert (dout == din);
  end
endmodule

// File: rtl/alu64_stream.sv
module alu64_stream
  import alu64_pkg::*;
#(
  parameter int unsigned W         = 64,
  parameter bit          SIGNED_LT = 1'b1,
  localparam int unsigned SW       = $clog2(W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [OP_W-1:0]     in_op,
  input  logic [W-1:0]        in_a,
  input  logic [W-1:0]        in_b,
  input  logic [SW-1:0]       in_shamt,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [W-1:0]        out_data
);
  alu_op_e      op;
  logic         sub_mode;
  logic [W-1:0] as_sum;
  logic         lt_bit;
  logic [W-1:0] sh_res [2];
  logic [W-1:0] result;
  logic         fire;

  assign op       = alu_op_e'(in_op);
  assign sub_mode = (op == OP_SUB) || (op == OP_LT);

  alu64_addsub #(.W(W)) u_addsub (
    .a   (in_a),
    .b   (in_b),
    .sub (sub_mode),
    .sum (as_sum)
  );

  alu64_lt #(.SIGNED_LT(SIGNED_LT)) u_lt (
    .a_msb    (in_a[W-1]),
    .b_msb    (in_b[W-1]),
    .diff_msb (as_sum[W-1]),
    .less     (lt_bit)
  );

  // Index 0 shifts right, index 1 shifts left
  for (genvar d = 0; d < 2; d++) begin : g_sh
    alu64_shift #(.W(W), .LEFT(d == 1)) u_sh (
      .din  (in_a),
      .amt  (in_shamt),
      .dout (sh_res[d])
    );
  end

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB: result = as_sum;
      OP_LT:          result = {{(W-1){1'b0}}, lt_bit};
      OP_SHR:         result = sh_res[0];
      OP_SHL:         result = sh_res[1];
      default:        result = '0;
    endcase
  end

  // Single output register; upstream may refill it in the cycle it drains
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (fire) begin
        out_valid <= 1'b1;
        out_data  <= result;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  a_r1_add_out : assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op == 4'b0001 |=> out_data == $past(in_a + in_b));

  a_r2_sub_out : assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op == 4'b0010 |=> out_data == $past(in_a - in_b));

  a_r3_bool_only : assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op == 4'b1011 |=> out_data[W-1:1] == '0);

  a_r6_no_rsvd : assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> in_op != 4'b1000);

  a_r6_unlisted_zero : assert property (@(posedge clk) disable iff (!rst_n)
    fire && !(in_op inside {4'b0001, 4'b0010, 4'b1011, 4'b1100, 4'b1110})
    |=> out_data == '0);

  a_r7_accept : assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  a_r8_hold : assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

endmodule

// File: tb/sim_alu64_stream.sv
module sim_alu64_stream;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic [5:0]  in_shamt = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alu64_stream u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_shamt(in_shamt),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [63:0] model(logic [3:0] op, logic [63:0] a,
                                        logic [63:0] b, logic [5:0] sh);
    case (op)
      4'b0001: return a + b;
      4'b0010: return a - b;
      4'b1011: return ($signed(a) < $signed(b)) ? 64'd1 : 64'd0;
      4'b1110: return a >> sh;
      4'b1100: return a << sh;
      default: return 64'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [3:0] op);
    case (op)
      4'b0001: return "R1";
      4'b0010: return "R2";
      4'b1011: return "R3";
      4'b1110: return "R4";
      4'b1100: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run_op(logic [3:0] op, logic [63:0] a, logic [63:0] b,
                        logic [5:0] sh);
    @(negedge clk);
    in_op = op; in_a = a; in_b = b; in_shamt = sh; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 valid", {63'd0, out_valid}, 64'd1);
    check(tag_of(op), out_data, model(op, a, b, sh));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] ra, rb;
    logic [3:0]  rop;
    void'($urandom(32'd4711));

    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9 out_valid", {63'd0, out_valid}, 64'd0);
    check("R9 in_ready", {63'd0, in_ready}, 64'd1);
    rst_n = 1'b1;

    // R1, R2: wrap-around
    run_op(4'b0001, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 6'd0);
    run_op(4'b0010, 64'd0, 64'd1, 6'd0);
    run_op(4'b0001, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 6'd0);
    // R3: signed corners
    run_op(4'b1011, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 6'd0);
    run_op(4'b1011, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 6'd0);
    run_op(4'b1011, 64'd5, 64'd5, 6'd0);
    run_op(4'b1011, 64'hFFFF_FFFF_FFFF_FFFB, 64'd5, 6'd0);
    run_op(4'b1011, 64'd5, 64'hFFFF_FFFF_FFFF_FFFB, 6'd0);
    // R4, R5: shift distances at the edges
    run_op(4'b1110, 64'hF000_0000_0000_000F, 64'd0, 6'd0);
    run_op(4'b1110, 64'hF000_0000_0000_000F, 64'd0, 6'd1);
    run_op(4'b1110, 64'hF000_0000_0000_000F, 64'd0, 6'd63);
    run_op(4'b1100, 64'hF000_0000_0000_000F, 64'd0, 6'd1);
    run_op(4'b1100, 64'hF000_0000_0000_000F, 64'd0, 6'd63);
    // R6: unlisted codes
    run_op(4'b0000, 64'd12, 64'd34, 6'd3);
    run_op(4'b1111, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 6'd3);

    // R8: stall holds data, then release takes the waiting op
    @(negedge clk);
    out_ready = 1'b0;
    in_op = 4'b0001; in_a = 64'd100; in_b = 64'd23; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_op = 4'b0010; in_a = 64'd100; in_b = 64'd23;
    check("R8 in_ready low", {63'd0, in_ready}, 64'd0);
    check("R8 data", out_data, 64'd123);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R8 held", out_data, 64'd123);
      check("R8 valid", {63'd0, out_valid}, 64'd1);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 next", out_data, 64'd77);
    check("R7 valid", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    check("R7 drained", {63'd0, out_valid}, 64'd0);

    // Random mix, never the reserved code
    for (int n = 0; n < 400; n++) begin
      case ($urandom % 8)
        0: rop = 4'b0001;
        1: rop = 4'b0010;
        2, 3: rop = 4'b1011;
        4: rop = 4'b1110;
        5: rop = 4'b1100;
        6: rop = 4'b0000;
        default: rop = 4'b0111;
      endcase
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      if ($urandom % 4 == 0) rb = ra;
      if ($urandom % 4 == 1) rb = {~ra[63], ra[62:0]};
      run_op(rop, ra, rb, 6'($urandom));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule